// File: doc/BRIEF.md
# Mirrored IO Address Decoder

This block decodes every access of a 32-bit processor bus to one of ten targets: main RAM, the boot ROM, and eight IO peripherals. For the access it picks one chip select and the byte offset inside that target. RAM sits at address zero, and its size is a parameter. The ROM occupies a fixed 1 MiB window. The IO peripherals live in a 64 MiB window that holds only one 256 KiB slice of real decode. Every other slice in the window is a mirror of that first one. The address is therefore reduced modulo the slice size before any peripheral is matched, so each alias reaches the same device at the same offset.

The decode itself is combinational. Its result is registered, so the select, the offset and the two error flags appear one clock after the bus-valid strobe, together with an acknowledge. Two kinds of access are still acknowledged but raise an error flag. An access that lands on no target raises the unmapped flag. A write to a read-only target (the boot ROM or the network address PROM) raises the read-only flag.

Top module: `mio_decode_top`

## Requirements
- R1: While reset is asserted, and on the first sampling after it is released, ack, all selects, both error flags and the offset are 0, even when bus_valid is held high.
- R2: For a strobe sampled at a rising edge, ack is 1 in the following cycle. After a cycle with bus_valid low, ack, the selects, both flags and the offset are all 0.
- R3: An address below RAM_BYTES asserts select bit 0 and presents offset = address. The address RAM_BYTES itself is unmapped.
- R4: An address from 0x4080_0000 through 0x408F_FFFF asserts select bit 1 with offset = address − 0x4080_0000. 0x4090_0000 is unmapped.
- R5: An address from 0x5000_0000 through 0x53FF_FFFF is IO. Its slice offset is (address − 0x5000_0000) mod 0x40000, so every alias decodes identically. 0x5400_0000 is unmapped.
- R6: The slice offset selects peripherals as follows, with offset = slice offset − base. Each base and size is given as bit:base/size:
  - 2: 0x00000/256, timer and port chip
  - 3: 0x08000/4096, network address PROM
  - 4: 0x0A000/256, network controller
  - 5: 0x0C020/256, serial controller
  - 6: 0x10000/256, SCSI
  - 7: 0x10100/256, SCSI pseudo-DMA
  - 8: 0x14000/256, sound
  - 9: 0x1E000/256, floppy
- R7: At most one select bit is ever high.
- R8: An acknowledged access that matches no target sets err_unmapped, asserts no select and presents offset 0. err_unmapped and err_readonly are never high together.
- R9: A write to the ROM (bit 1) or the PROM (bit 3) is acknowledged with err_readonly = 1, no select and the normal offset. A read of those regions, or a write to any other target, leaves err_readonly at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| resp_ack | output | 1 | Registered acknowledge |
| resp_sel | output | 10 | One-hot chip select (bit order per R3, R4, R6) |
| resp_off | output | 30 | Byte offset within the selected target |
| resp_err_unmapped | output | 1 | Access hit no target |
| resp_err_readonly | output | 1 | Write to ROM or PROM |

## Verification
The first and last byte of every region are driven, along with the byte just past each one. This separates off-by-one errors in the limits from wrong bases. The same slice offsets are repeated in the second and the last mirror slice, and pseudo-random addresses cluster around the peripheral bases across all 256 slices. A decoder that ignores the modulo reduction, or that still looks at the slice number, then diverges from the reference model. Reads and writes are interleaved on the same targets, so that the read-only flag separates the PROM and ROM from the other targets. Back-to-back and idle cycles expose a response stage that holds stale values.

// File: rtl/mio_pkg.sv
package mio_pkg;

  typedef logic [31:0] addr_t;

  localparam int unsigned DEV_N    = 8;
  localparam int unsigned SEL_N    = DEV_N + 2;
  localparam int unsigned SEL_RAM  = 0;
  localparam int unsigned SEL_ROM  = 1;
  localparam int unsigned SEL_DEV0 = 2;
  localparam int unsigned DEV_PROM = 1;  // index within the peripheral list

  // peripheral placement inside one IO slice; the select order follows the index
  localparam addr_t DEV_BASE [DEV_N] = '{
    32'h0000_0000, 32'h0000_8000, 32'h0000_A000, 32'h0000_C020,
    32'h0001_0000, 32'h0001_0100, 32'h0001_4000, 32'h0001_E000
  };
  localparam addr_t DEV_SIZE [DEV_N] = '{
    32'd256, 32'd4096, 32'd256, 32'd256,
    32'd256, 32'd256,  32'd256, 32'd256
  };

  // true when base <= a < base + size, evaluated without wrap-around
  function automatic logic window_hit(addr_t a, addr_t base, addr_t size);
    logic [32:0] lim;
    lim = {1'b0, base} + {1'b0, size};
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction

  // reduce an address to its position inside a power-of-two slice
  function automatic addr_t slice_fold(addr_t a, addr_t base, addr_t slice_bytes);
    addr_t rel;
    rel = a - base;
    return rel & (slice_bytes - 32'd1);
  endfunction

endpackage

// File: rtl/mio_mem_decode.sv
module mio_mem_decode
  import mio_pkg::*;
#(
  parameter addr_t       RAM_BYTES = 32'h0800_0000,
  parameter addr_t       ROM_BASE  = 32'h4080_0000,
  parameter addr_t       ROM_BYTES = 32'h0010_0000,
  parameter int unsigned OFF_W     = 30
) (
  input  addr_t            addr,
  output logic             ram_hit,
  output logic             rom_hit,
  output logic [OFF_W-1:0] ram_off,
  output logic [OFF_W-1:0] rom_off
);

  addr_t rom_rel;

  always_comb begin
    ram_hit = window_hit(addr, 32'h0, RAM_BYTES);
    rom_hit = window_hit(addr, ROM_BASE, ROM_BYTES);
    rom_rel = addr - ROM_BASE;
    ram_off = ram_hit ? addr[OFF_W-1:0] : '0;
    rom_off = rom_hit ? rom_rel[OFF_W-1:0] : '0;
  end

endmodule

// File: rtl/mio_io_decode.sv
module mio_io_decode
  import mio_pkg::*;
#(
  parameter addr_t       IO_BASE     = 32'h5000_0000,
  parameter addr_t       IO_SPAN     = 32'h0400_0000,
  parameter addr_t       SLICE_BYTES = 32'h0004_0000,
  parameter int unsigned OFF_W       = 30
) (
  input  addr_t            addr,
  output logic             io_hit,
  output logic [DEV_N-1:0] dev_hit,
  output logic [OFF_W-1:0] dev_off
);

  addr_t            slice_off;
  logic [OFF_W-1:0] part_off [DEV_N];

  always_comb begin
    io_hit    = window_hit(addr, IO_BASE, IO_SPAN);
    slice_off = slice_fold(addr, IO_BASE, SLICE_BYTES);
  end

  for (genvar g = 0; g < DEV_N; g++) begin : g_dev
    addr_t rel;
    always_comb begin
      dev_hit[g]  = io_hit && window_hit(slice_off, DEV_BASE[g], DEV_SIZE[g]);
      rel         = slice_off - DEV_BASE[g];
      part_off[g] = dev_hit[g] ? rel[OFF_W-1:0] : '0;
    end
  end

  // regions are disjoint, so an OR of the masked offsets acts as the mux
  always_comb begin
    dev_off = '0;
    for (int i = 0; i < DEV_N; i++) dev_off = dev_off | part_off[i];
  end

endmodule

// File: rtl/mio_resp_reg.sv
module mio_resp_reg #(
  parameter int unsigned SEL_W = 10,
  parameter int unsigned OFF_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_d,
  input  logic [SEL_W-1:0] sel_d,
  input  logic [OFF_W-1:0] off_d,
  input  logic             unm_d,
  input  logic             ro_d,
  output logic             ack_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [OFF_W-1:0] off_q,
  output logic             unm_q,
  output logic             ro_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      sel_q <= '0;
      off_q <= '0;
      unm_q <= 1'b0;
      ro_q  <= 1'b0;
    end else begin
      ack_q <= ack_d;
      sel_q <= sel_d;
      off_q <= off_d;
      unm_q <= unm_d;
      ro_q  <= ro_d;
    end
  end

endmodule

// File: rtl/mio_decode_top.sv
module mio_decode_top
  import mio_pkg::*;
#(
  parameter addr_t       RAM_BYTES   = 32'h0800_0000,
  parameter addr_t       ROM_BASE    = 32'h4080_0000,
  parameter addr_t       ROM_BYTES   = 32'h0010_0000,
  parameter addr_t       IO_BASE     = 32'h5000_0000,
  parameter addr_t       IO_SPAN     = 32'h0400_0000,
  parameter addr_t       SLICE_BYTES = 32'h0004_0000,
  parameter int unsigned OFF_W       = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [31:0]      bus_addr,
  output logic             resp_ack,
  output logic [9:0]       resp_sel,
  output logic [29:0]      resp_off,
  output logic             resp_err_unmapped,
  output logic             resp_err_readonly
);

  logic             ram_hit, rom_hit, io_hit;
  logic [OFF_W-1:0] ram_off, rom_off, dev_off;
  logic [DEV_N-1:0] dev_hit;

  // named decode events, also observed by the checker
  logic [SEL_N-1:0] hit_vec;
  logic             any_hit;
  logic             ro_viol;
  logic             unmapped;
  logic [SEL_N-1:0] sel_d;
  logic [OFF_W-1:0] off_mux, off_d;

  mio_mem_decode #(
    .RAM_BYTES(RAM_BYTES), .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES), .OFF_W(OFF_W)
  ) mem_i (
    .addr(bus_addr), .ram_hit(ram_hit), .rom_hit(rom_hit),
    .ram_off(ram_off), .rom_off(rom_off)
  );

  mio_io_decode #(
    .IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN), .SLICE_BYTES(SLICE_BYTES), .OFF_W(OFF_W)
  ) io_i (
    .addr(bus_addr), .io_hit(io_hit), .dev_hit(dev_hit), .dev_off(dev_off)
  );

  always_comb begin
    hit_vec  = {dev_hit, rom_hit, ram_hit};
    any_hit  = |hit_vec;
    ro_viol  = bus_valid && bus_write && (rom_hit || dev_hit[DEV_PROM]);
    unmapped = bus_valid && !any_hit;
    sel_d    = (bus_valid && !ro_viol) ? hit_vec : '0;
    if (ram_hit)      off_mux = ram_off;
    else if (rom_hit) off_mux = rom_off;
    else if (io_hit)  off_mux = dev_off;
    else              off_mux = '0;
    off_d    = bus_valid ? off_mux : '0;
  end

  mio_resp_reg #(.SEL_W(SEL_N), .OFF_W(OFF_W)) resp_i (
    .clk(clk), .rst_n(rst_n),
    .ack_d(bus_valid), .sel_d(sel_d), .off_d(off_d),
    .unm_d(unmapped), .ro_d(ro_viol),
    .ack_q(resp_ack), .sel_q(resp_sel), .off_q(resp_off),
    .unm_q(resp_err_unmapped), .ro_q(resp_err_readonly)
  );

endmodule

// File: rtl/mio_decode_chk.sv
module mio_decode_chk #(
  parameter int unsigned SEL_W = 10,
  parameter int unsigned OFF_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic [SEL_W-1:0] hit_vec,
  input logic             ro_viol,
  input logic             resp_ack,
  input logic [SEL_W-1:0] resp_sel,
  input logic [OFF_W-1:0] resp_off,
  input logic             resp_err_unmapped,
  input logic             resp_err_readonly
);

  // R2
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> resp_ack);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (!resp_ack && resp_sel == '0 && resp_off == '0 &&
                    !resp_err_unmapped && !resp_err_readonly));

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp_sel));

  // R7
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8
  unmapped_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err_unmapped |-> (resp_sel == '0 && resp_off == '0 && resp_ack));

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_err_unmapped && resp_err_readonly));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_viol |=> (resp_ack && resp_err_readonly && resp_sel == '0));

endmodule

bind mio_decode_top mio_decode_chk #(.SEL_W(mio_pkg::SEL_N), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .hit_vec(hit_vec),
  .ro_viol(ro_viol), .resp_ack(resp_ack), .resp_sel(resp_sel),
  .resp_off(resp_off), .resp_err_unmapped(resp_err_unmapped),
  .resp_err_readonly(resp_err_readonly)
);

// File: tb/mio_decode_top_tb_top.sv
`timescale 1ns/1ps
module mio_decode_top_tb_top;

  localparam logic [31:0] TB_RAM = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        resp_ack;
  logic [9:0]  resp_sel;
  logic [29:0] resp_off;
  logic        resp_err_unmapped;
  logic        resp_err_readonly;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // expected response for the access driven in the previous cycle
  logic        e_ack = 0;
  logic [9:0]  e_sel = '0;
  longint      e_off = 0;
  logic        e_unm = 0;
  logic        e_ro = 0;
  string       e_tag = "R2";

  always #2 clk = ~clk;

  mio_decode_top #(.RAM_BYTES(TB_RAM)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .resp_ack(resp_ack), .resp_sel(resp_sel),
    .resp_off(resp_off), .resp_err_unmapped(resp_err_unmapped),
    .resp_err_readonly(resp_err_readonly)
  );

  // behavioural reference: returns target number (-1 none) and offset
  function automatic void ref_map(input longint a, output int tgt, output longint off);
    longint so;
    longint bases [8] = '{'h0, 'h8000, 'hA000, 'hC020, 'h10000, 'h10100, 'h14000, 'h1E000};
    longint sizes [8] = '{256, 4096, 256, 256, 256, 256, 256, 256};
    tgt = -1; off = 0;
    if (a < longint'(TB_RAM)) begin tgt = 0; off = a; end
    else if (a >= 'h4080_0000 && a < 'h4090_0000) begin tgt = 1; off = a - 'h4080_0000; end
    else if (a >= 'h5000_0000 && a < 'h5400_0000) begin
      so = (a - 'h5000_0000) % 262144;
      foreach (bases[k])
        if (so >= bases[k] && so < bases[k] + sizes[k]) begin tgt = k + 2; off = so - bases[k]; end
    end
  endfunction

  task automatic compare();
    logic ok;
    checks++;
    ok = (resp_ack === e_ack) && (resp_sel === e_sel) && (longint'(resp_off) == e_off) &&
         (resp_err_unmapped === e_unm) && (resp_err_readonly === e_ro);
    if (!ok) begin
      failures++;
      $display("FAIL %s: got ack=%b sel=%b off=%h unm=%b ro=%b, want ack=%b sel=%b off=%h unm=%b ro=%b",
               e_tag, resp_ack, resp_sel, resp_off, resp_err_unmapped, resp_err_readonly,
               e_ack, e_sel, e_off, e_unm, e_ro);
    end
  endtask

  // one bus cycle: check the previous access, then drive the next
  task automatic step(input bit v, input bit w, input longint a, input string tag);
    int     t;
    longint o;
    @(negedge clk);
    compare();
    bus_valid = v; bus_write = w; bus_addr = a[31:0];
    e_tag = tag;
    e_ack = v; e_sel = '0; e_off = 0; e_unm = 0; e_ro = 0;
    if (v) begin
      ref_map(a, t, o);
      if (t < 0) e_unm = 1;
      else begin
        e_off = o;
        e_ro  = w && (t == 1 || t == 3);
        if (!e_ro) e_sel = 10'b1 << t;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got running, want finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint bases [8] = '{'h0, 'h8000, 'hA000, 'hC020, 'h10000, 'h10100, 'h14000, 'h1E000};
    longint lasts [8] = '{'hFF, 'h8FFF, 'hA0FF, 'hC11F, 'h100FF, 'h101FF, 'h140FF, 'h1E0FF};
    int unsigned x = 32'h1234_5679;
    // R1: reset holds everything low even with valid high
    bus_valid = 1; bus_addr = 32'h0000_0010;
    repeat (3) begin @(negedge clk); e_tag = "R1"; compare(); end
    @(negedge clk); rst_n = 1; bus_valid = 0;
    e_tag = "R1"; compare();

    step(0, 0, 0, "R2");
    // R3 RAM limits and writes
    step(1, 0, 0, "R3");
    step(1, 1, 'h0000_1234, "R3");
    step(1, 0, longint'(TB_RAM) - 1, "R3");
    step(1, 0, longint'(TB_RAM), "R8");
    step(0, 0, 0, "R2");
    // R4 ROM limits
    step(1, 0, 'h4080_0000, "R4");
    step(1, 0, 'h408F_FFFF, "R4");
    step(1, 0, 'h4090_0000, "R8");
    step(1, 0, 'h407F_FFFF, "R8");
    // R9 read-only writes
    step(1, 1, 'h4080_0040, "R9");
    step(1, 1, 'h5000_8010, "R9");
    step(1, 0, 'h5000_8010, "R9");
    step(1, 1, 'h5000_A004, "R9");
    step(1, 1, 'h53FC_8FFF, "R9");
    // R6 every peripheral, first and last byte, slice 0
    for (int k = 0; k < 8; k++) begin
      step(1, 0, 'h5000_0000 + bases[k], "R6");
      step(1, 0, 'h5000_0000 + lasts[k], "R6");
      step(1, 0, 'h5000_0000 + lasts[k] + 1, "R6");
    end
    // R5 mirrors in second and last slice and window edges
    for (int k = 0; k < 8; k++) begin
      step(1, 0, 'h5004_0000 + bases[k] + 3, "R5");
      step(1, 0, 'h53FC_0000 + lasts[k], "R5");
    end
    step(1, 0, 'h53FF_FFFF, "R5");
    step(1, 0, 'h5400_0000, "R5");
    step(1, 0, 'h4FFF_FFFF, "R8");
    step(1, 0, 'h5000_C01F, "R8");
    step(1, 0, 'hFFFF_FFFF, "R8");
    step(0, 1, 'h5000_0000, "R2");
    step(0, 0, 'h4080_0000, "R2");
    // R5/R7 pseudo-random accesses clustered around peripherals
    for (int n = 0; n < 400; n++) begin
      longint a;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      a = 'h5000_0000 + longint'((x >> 3) % 256) * 'h40000 +
          bases[x % 8] + longint'((x >> 12) % 300);
      step((x >> 28) != 0, x[20], a, "R7");
    end
    step(0, 0, 0, "R2");
    step(0, 0, 0, "R2");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule